// File: doc/BRIEF.md
# USB Host Interrupt Event Controller

This block gathers the events of one USB host port and reduces them to one interrupt request line. Six event sources feed it. Two are the OTG signals, the VBUS-valid comparator output and the ID pin, and they count on either edge. One is the port A line state, watched for a device being attached or detached. The others are a remote-wakeup detect pulse, a frame (SOF/EOP) timer tick and a transfer-completion strobe. The strobe carries a 3-bit handshake result. Each source owns one bit position in a 16-bit enable register and the same position in a 16-bit status register.

A status bit latches when its event occurs, whether or not the event is enabled. Software clears a status bit by writing a 1 to it. The interrupt line is the registered OR of all status bits whose enable bit is also set. A small register port selects the enable register, the status register or an empty slot, and it reads combinationally and writes on the clock edge. The parameter `HOST_INDEX` picks the first instance (1) or the second instance (2). The second instance has no OTG events, and its two OTG bit positions are hard zero.

The VBUS, ID and line-state inputs are asynchronous. Each passes through a `SYNC_STAGES`-deep synchronizer before any edge is detected. Line states are also filtered: a state must show on `STABLE_CYC` consecutive synchronized samples before it is accepted.

The connect detector is a four-state machine:
- **CON_UNKNOWN**: the state after reset.
- **CON_SE0**: SE0 has settled.
- **CON_J**: J has settled.
- **CON_OTHER**: K or SE1 has settled.

Whenever a newly settled state differs from the current one, the machine moves to that state. Only two of these moves raise the connect event: CON_SE0→CON_J (attach) and CON_J→CON_SE0 (detach). Every move out of CON_UNKNOWN, and every move into or out of CON_OTHER, is silent.

Top module: `usb_host_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0. Register select `reg_sel_i` = 0 addresses the enable register, 1 addresses the status register, and 2 or 3 read 0 and ignore writes. A write to the enable register keeps only the implemented bits. With `HOST_INDEX`=1 these are bit 15 (VBUS), 14 (ID), 9 (frame tick), 6 (wakeup), 4 (connect) and 0 (done), so writing 0xFFFF reads back 0xC251. Every other bit reads 0.
- R2: With `HOST_INDEX`=2, bits 15 and 14 of both registers read 0 and ignore writes, so writing 0xFFFF to the enable register reads back 0x0251. Toggling VBUS or ID never sets a status bit.
- R3: Every rising and every falling edge of `vbus_valid_i`, after synchronization, sets status bit 15.
- R4: Every rising and every falling edge of `otg_id_i`, after synchronization, sets status bit 14.
- R5: `line_state_i` is encoded as 00 = SE0, 01 = J, 10 = K, 11 = SE1. A state counts only after it has held on `STABLE_CYC` consecutive synchronized samples. A settled change from SE0 to J, or from J to SE0, sets status bit 4. A shorter glitch, the first state after reset, and any path through K or SE1 (for example SE0→K→J or K→SE0) set nothing.
- R6: A one-cycle `wake_pulse_i` sets status bit 6.
- R7: A one-cycle `frame_tick_i` sets status bit 9.
- R8: `xfer_done_i` sets status bit 0 when `xfer_result_i` is 1 (ACK), 2 (NAK), 3 (STALL) or 4 (timeout). The codes 0, 5, 6 and 7 are ignored.
- R9: A status bit stays set whether or not its enable bit is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: If an event arrives on the same clock edge as a write-one-to-clear of its bit, the bit ends up set.
- R11: `irq_o` is a register holding the OR of (status AND enable). It rises one clock after an enabled status bit is set, or after the enable bit of an already-set status bit is written. It falls one clock after the last enabled status bit clears.
- R12: Status and `irq_o` are 0 after reset. OTG and connect events are suppressed for the first `SYNC_STAGES`+`STABLE_CYC`-1 clocks after reset, so input levels held through reset raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_valid_i | input | 1 | VBUS-valid comparator output, asynchronous |
| otg_id_i | input | 1 | OTG ID pin, asynchronous |
| line_state_i | input | 2 | Port A line state (00 SE0, 01 J, 10 K, 11 SE1), asynchronous |
| wake_pulse_i | input | 1 | Remote-wakeup detect pulse, synchronous |
| frame_tick_i | input | 1 | SOF/EOP timer tick, synchronous |
| xfer_done_i | input | 1 | Transfer-completion strobe |
| xfer_result_i | input | 3 | Handshake result of the completed transfer |
| reg_sel_i | input | 2 | Register select (0 enable, 1 status) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:
- **Short line-state glitch.** A one-sample glitch must not qualify. An edge detector without the settle filter would report a phantom attach.
- **Paths through K.** Routes such as SE0→K→J must stay silent. A design that decodes only the end state would raise the event on these paths.
- **Set versus clear on one edge.** When an event and a clear of its bit share an edge, a design that lets the clear win would drop the event.
- **Input levels held through reset.** Asserted VBUS and ID levels held across reset must not create edges when the synchronizers fill.
- **Handshake codes.** All eight result codes are tried, to catch a decoder that accepts the unused values.
- **Second instance.** The host-2 copy is driven with the same stimulus. Any leak of OTG bits there shows up as nonzero readback.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    // Register width and event bit positions (software decodes these)
    localparam int REG_W     = 16;
    localparam int BIT_VBUS  = 15;
    localparam int BIT_ID    = 14;
    localparam int BIT_FRAME = 9;
    localparam int BIT_WAKE  = 6;
    localparam int BIT_CONN  = 4;
    localparam int BIT_DONE  = 0;

    // Register port selection
    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;

    // Line state encoding on the input pins
    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;

    // Handshake result codes that complete a transfer
    localparam logic [2:0] HS_ACK     = 3'd1;
    localparam logic [2:0] HS_NAK     = 3'd2;
    localparam logic [2:0] HS_STALL   = 3'd3;
    localparam logic [2:0] HS_TIMEOUT = 3'd4;

    // Settled connect state
    typedef enum logic [1:0] {
        CON_UNKNOWN = 2'd0,
        CON_SE0     = 2'd1,
        CON_J       = 2'd2,
        CON_OTHER   = 2'd3
    } con_state_t;

    // Bits that exist for a given host instance
    function automatic logic [REG_W-1:0] impl_mask(input int host);
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_FRAME] = 1'b1;
        m[BIT_WAKE]  = 1'b1;
        m[BIT_CONN]  = 1'b1;
        m[BIT_DONE]  = 1'b1;
        if (host == 1) begin
            m[BIT_VBUS] = 1'b1;
            m[BIT_ID]   = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/irq_conn_detect.sv
module irq_conn_detect
    import usb_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_i,
    input  logic [1:0] line_i,
    output logic       hit_o
);

    localparam int HIST = (STABLE_CYC > 1) ? STABLE_CYC - 1 : 1;

    logic [1:0] ls_sync;
    logic [1:0] hist [HIST];
    logic       agree;
    logic       qual;
    con_state_t state_q, state_d, target;

    irq_sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_ls_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (ls_sync)
    );

    // Past synchronized samples for the settle filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) begin
                hist[i] <= '0;
            end
        end else begin
            hist[0] <= ls_sync;
            for (int i = 1; i < HIST; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    always_comb begin
        agree = 1'b1;
        for (int i = 0; i < HIST; i++) begin
            if (hist[i] != ls_sync) begin
                agree = 1'b0;
            end
        end
    end

    assign qual = warm_i && agree;

    always_comb begin
        unique case (ls_sync)
            LINE_SE0: target = CON_SE0;
            LINE_J:   target = CON_J;
            default:  target = CON_OTHER;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CON_UNKNOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and event output
    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        if (qual && (target != state_q)) begin
            state_d = target;
            unique case (state_q)
                CON_SE0:     hit_o = (target == CON_J);
                CON_J:       hit_o = (target == CON_SE0);
                CON_UNKNOWN: hit_o = 1'b0;
                CON_OTHER:   hit_o = 1'b0;
            endcase
        end
    end

    // R5
    conn_attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && state_q == CON_SE0) |=> (state_q == CON_J));

    // R5
    conn_detach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && state_q == CON_J) |=> (state_q == CON_SE0));

    // R5
    conn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (state_q == $past(state_q)));

endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
    import usb_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] hit_i,
    input  logic [1:0]       sel_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o
);

    logic [REG_W-1:0] en_q, en_d;
    logic [REG_W-1:0] st_q, st_d;
    logic [REG_W-1:0] clr;
    logic             irq_q;

    always_comb begin
        clr  = (wr_i && sel_i == SEL_STATUS) ? wdata_i : '0;
        st_d = ((st_q & ~clr) | hit_i) & IMPL_MASK;
        en_d = (wr_i && sel_i == SEL_ENABLE) ? (wdata_i & IMPL_MASK) : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            st_q  <= st_d;
            irq_q <= |(st_q & en_q);
        end
    end

    always_comb begin
        unique case (sel_i)
            SEL_ENABLE: rdata_o = en_q;
            SEL_STATUS: rdata_o = st_q;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

    // R1
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_ENABLE) |=> (en_q == ($past(wdata_i) & IMPL_MASK)));

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_STATUS && hit_i == '0) |=> ((st_q & $past(wdata_i)) == '0));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_STATUS) |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((st_q & $past(hit_i & IMPL_MASK)) == $past(hit_i & IMPL_MASK)));

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q & en_q)) |=> irq_o);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q & en_q)) |=> !irq_o);

endmodule

// File: rtl/usb_host_irq_ctrl.sv
module usb_host_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int HOST_INDEX  = 1,
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vbus_valid_i,
    input  logic        otg_id_i,
    input  logic [1:0]  line_state_i,
    input  logic        wake_pulse_i,
    input  logic        frame_tick_i,
    input  logic        xfer_done_i,
    input  logic [2:0]  xfer_result_i,
    input  logic [1:0]  reg_sel_i,
    input  logic        reg_wr_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic        irq_o
);

    localparam int               WARM_CYC  = SYNC_STAGES + STABLE_CYC - 1;
    localparam int               WARM_W    = $clog2(WARM_CYC + 1);
    localparam logic [REG_W-1:0] IMPL_MASK = impl_mask(HOST_INDEX);

    logic [WARM_W-1:0] warm_cnt;
    logic              warm_ok;
    logic [1:0]        otg_edge;
    logic              conn_hit;
    logic              done_ok;
    logic [REG_W-1:0]  events;

    // Start-up window while synchronizer stages hold reset values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (!warm_ok) begin
            warm_cnt <= warm_cnt + 1'b1;
        end
    end

    assign warm_ok = (warm_cnt == WARM_W'(WARM_CYC));

    generate
        if (HOST_INDEX == 1) begin : g_otg
            logic [1:0] otg_sync;
            logic [1:0] otg_prev;

            irq_sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_otg_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   ({vbus_valid_i, otg_id_i}),
                .q_o   (otg_sync)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    otg_prev <= '0;
                end else begin
                    otg_prev <= otg_sync;
                end
            end

            assign otg_edge = warm_ok ? (otg_sync ^ otg_prev) : 2'b00;
        end else begin : g_no_otg
            assign otg_edge = 2'b00;
        end
    endgenerate

    irq_conn_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (STABLE_CYC)
    ) u_conn (
        .clk    (clk),
        .rst_n  (rst_n),
        .warm_i (warm_ok),
        .line_i (line_state_i),
        .hit_o  (conn_hit)
    );

    always_comb begin
        done_ok = 1'b0;
        if (xfer_done_i) begin
            unique case (xfer_result_i)
                HS_ACK, HS_NAK, HS_STALL, HS_TIMEOUT: done_ok = 1'b1;
                default:                              done_ok = 1'b0;
            endcase
        end
    end

    always_comb begin
        events            = '0;
        events[BIT_VBUS]  = otg_edge[1];
        events[BIT_ID]    = otg_edge[0];
        events[BIT_FRAME] = frame_tick_i;
        events[BIT_WAKE]  = wake_pulse_i;
        events[BIT_CONN]  = conn_hit;
        events[BIT_DONE]  = done_ok;
    end

    irq_event_regs #(.IMPL_MASK(IMPL_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (events),
        .sel_i   (reg_sel_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .irq_o   (irq_o)
    );

    // R12
    no_early_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_ok && !reg_wr_i && events == '0 && $past(!warm_ok)) |=> (reg_sel_i != SEL_STATUS || reg_rdata_o == '0 || warm_ok));

endmodule

// File: tb/tb_usb_host_irq_ctrl.sv
module tb_usb_host_irq_ctrl;

    localparam int SYNC   = 2;
    localparam int STABLE = 2;
    localparam int WARM   = SYNC + STABLE - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vbus = 1'b1;
    logic        id = 1'b1;
    logic [1:0]  ls = 2'b01;
    logic        wake = 1'b0;
    logic        tick = 1'b0;
    logic        done = 1'b0;
    logic [2:0]  res = 3'd0;
    logic [1:0]  sel = 2'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rd1, rd2;
    logic        irq1, irq2;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // 250 MHz: 4 ns period
    always #2 clk = ~clk;

    usb_host_irq_ctrl #(.HOST_INDEX(1), .SYNC_STAGES(SYNC), .STABLE_CYC(STABLE)) dut (
        .clk(clk), .rst_n(rst_n), .vbus_valid_i(vbus), .otg_id_i(id),
        .line_state_i(ls), .wake_pulse_i(wake), .frame_tick_i(tick),
        .xfer_done_i(done), .xfer_result_i(res), .reg_sel_i(sel),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rd1), .irq_o(irq1)
    );

    usb_host_irq_ctrl #(.HOST_INDEX(2), .SYNC_STAGES(SYNC), .STABLE_CYC(STABLE)) dut_h2 (
        .clk(clk), .rst_n(rst_n), .vbus_valid_i(vbus), .otg_id_i(id),
        .line_state_i(ls), .wake_pulse_i(wake), .frame_tick_i(tick),
        .xfer_done_i(done), .xfer_result_i(res), .reg_sel_i(sel),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rd2), .irq_o(irq2)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] mask [2];
    logic [15:0] men  [2];
    logic [15:0] mst  [2];
    logic        mirq [2];
    int vh [8];
    int ih [8];
    int lh [8];
    int mcon;
    int mcyc;

    function automatic int line_code(input int v);
        if (v == 0) return 1;
        if (v == 1) return 2;
        return 3;
    endfunction

    initial begin
        mask[0] = 16'hC251;
        mask[1] = 16'h0251;
        for (int h = 0; h < 2; h++) begin
            men[h] = '0; mst[h] = '0; mirq[h] = 1'b0;
        end
        for (int d = 0; d < 8; d++) begin
            vh[d] = 0; ih[d] = 0; lh[d] = 0;
        end
        mcon = 0;
        mcyc = 0;
    end

    always @(posedge clk) begin
        logic [15:0] hits;
        logic [15:0] clr;
        bit warm;
        bit agree;
        int tgt;
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) begin
                men[h] = '0; mst[h] = '0; mirq[h] = 1'b0;
            end
            mcon = 0;
            mcyc = 0;
        end else begin
            mcyc++;
            for (int d = 7; d > 0; d--) begin
                vh[d] = vh[d-1]; ih[d] = ih[d-1]; lh[d] = lh[d-1];
            end
            vh[0] = int'(vbus);
            ih[0] = int'(id);
            lh[0] = int'(ls);
            warm = (mcyc - 1) >= WARM;
            hits = '0;
            if (warm && vh[SYNC] != vh[SYNC+1]) hits[15] = 1'b1;
            if (warm && ih[SYNC] != ih[SYNC+1]) hits[14] = 1'b1;
            agree = 1'b1;
            for (int d = SYNC + 1; d < SYNC + STABLE; d++) begin
                if (lh[d] != lh[SYNC]) agree = 1'b0;
            end
            tgt = line_code(lh[SYNC]);
            if (warm && agree && tgt != mcon) begin
                if ((mcon == 1 && tgt == 2) || (mcon == 2 && tgt == 1)) hits[4] = 1'b1;
                mcon = tgt;
            end
            if (wake) hits[6] = 1'b1;
            if (tick) hits[9] = 1'b1;
            if (done && res >= 3'd1 && res <= 3'd4) hits[0] = 1'b1;
            clr = (wr && sel == 2'd1) ? wdata : 16'h0;
            for (int h = 0; h < 2; h++) begin
                mirq[h] = |(mst[h] & men[h]);
                mst[h]  = ((mst[h] & ~clr) | hits) & mask[h];
                if (wr && sel == 2'd0) men[h] = wdata & mask[h];
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R11 irq host1", {15'h0, irq1}, {15'h0, mirq[0]});
            check("R11 irq host2", {15'h0, irq2}, {15'h0, mirq[1]});
            if (sel == 2'd0) begin
                check("R1 enable host1", rd1, men[0]);
                check("R2 enable host2", rd2, men[1]);
            end else if (sel == 2'd1) begin
                check("R9 status host1", rd1, mst[0]);
                check("R9 status host2", rd2, mst[1]);
            end else begin
                check("R1 unmapped host1", rd1, 16'h0);
                check("R1 unmapped host2", rd2, 16'h0);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [15:0] v);
        sel = s; wr = 1'b1; wdata = v;
        step(1);
        wr = 1'b0; wdata = 16'h0;
    endtask

    task automatic read_status(input string tag, input logic [15:0] e1, input logic [15:0] e2);
        sel = 2'd1;
        step(1);
        check(tag, rd1, e1);
        check(tag, rd2, e2);
    endtask

    task automatic clear_all();
        reg_write(2'd1, 16'hFFFF);
        step(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(12);

        // R12: levels held across reset raise nothing
        read_status("R12 status after reset", 16'h0, 16'h0);
        check("R12 irq after reset", {15'h0, irq1}, 16'h0);

        // R1 / R2: implemented bits
        reg_write(2'd0, 16'hFFFF);
        sel = 2'd0; step(1);
        check("R1 enable mask host1", rd1, 16'hC251);
        check("R2 enable mask host2", rd2, 16'h0251);
        reg_write(2'd2, 16'hFFFF);
        sel = 2'd2; step(1);
        check("R1 unmapped reads zero", rd1, 16'h0);
        sel = 2'd0; step(1);
        check("R1 unmapped write ignored", rd1, 16'hC251);

        // R6 wakeup
        wake = 1'b1; step(1); wake = 1'b0; step(3);
        read_status("R6 wakeup status", 16'h0040, 16'h0040);
        check("R11 irq raised", {15'h0, irq1}, 16'h1);
        clear_all();
        check("R11 irq dropped", {15'h0, irq1}, 16'h0);

        // R7 frame tick
        tick = 1'b1; step(1); tick = 1'b0; step(3);
        read_status("R7 frame status", 16'h0200, 16'h0200);
        clear_all();

        // R8 handshake codes
        for (int r = 0; r < 8; r++) begin
            done = 1'b1; res = 3'(r); step(1); done = 1'b0; res = 3'd0; step(3);
            read_status("R8 done code", (r >= 1 && r <= 4) ? 16'h0001 : 16'h0000,
                        (r >= 1 && r <= 4) ? 16'h0001 : 16'h0000);
            clear_all();
        end

        // R3 VBUS both edges, R2 no effect on host2
        vbus = 1'b0; step(8);
        read_status("R3 vbus fall", 16'h8000, 16'h0000);
        clear_all();
        vbus = 1'b1; step(8);
        read_status("R3 vbus rise", 16'h8000, 16'h0000);
        clear_all();

        // R4 ID both edges
        id = 1'b0; step(8);
        read_status("R4 id fall", 16'h4000, 16'h0000);
        clear_all();
        id = 1'b1; step(8);
        read_status("R4 id rise", 16'h4000, 16'h0000);
        clear_all();

        // R5 connect change
        ls = 2'b00; step(8);
        read_status("R5 detach", 16'h0010, 16'h0010);
        clear_all();
        ls = 2'b01; step(8);
        read_status("R5 attach", 16'h0010, 16'h0010);
        clear_all();
        ls = 2'b00; step(1); ls = 2'b01; step(8);
        read_status("R5 glitch ignored", 16'h0, 16'h0);
        ls = 2'b10; step(8);
        ls = 2'b00; step(8);
        read_status("R5 K to SE0 silent", 16'h0, 16'h0);
        ls = 2'b01; step(8);
        read_status("R5 SE0 to J", 16'h0010, 16'h0010);
        clear_all();
        ls = 2'b00; step(8);
        clear_all();
        ls = 2'b10; step(8);
        ls = 2'b01; step(8);
        read_status("R5 SE0-K-J silent", 16'h0, 16'h0);

        // R9 sticky while disabled, R11 enable later raises irq
        reg_write(2'd0, 16'h0000);
        wake = 1'b1; step(1); wake = 1'b0; step(3);
        read_status("R9 sticky disabled", 16'h0040, 16'h0040);
        check("R9 irq stays low", {15'h0, irq1}, 16'h0);
        reg_write(2'd0, 16'h0040);
        step(2);
        check("R11 irq after enable", {15'h0, irq1}, 16'h1);
        reg_write(2'd1, 16'h0000);
        read_status("R9 write zero keeps", 16'h0040, 16'h0040);
        clear_all();
        check("R11 irq after clear", {15'h0, irq1}, 16'h0);

        // R10 event and clear on the same edge
        sel = 2'd1; wr = 1'b1; wdata = 16'hFFFF; wake = 1'b1;
        step(1);
        wr = 1'b0; wdata = 16'h0; wake = 1'b0;
        step(2);
        read_status("R10 set wins", 16'h0040, 16'h0040);
        check("R10 irq", {15'h0, irq1}, 16'h1);
        clear_all();
        step(4);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule